// File: doc/BRIEF.md
# Carrier Presence Qualifier with Dropout Hysteresis

This block decides whether an FSK carrier is present on a telephone line. It looks at an in-band energy estimate once per sample strobe. That estimate comes from a front-end filter or from the demodulator's correlators. The block drives an active-low presence flag. The flag falls only after the energy has stayed above an upper threshold for a full acquisition interval. It rises again only after the energy has stayed below a lower threshold for a full release interval. A short gap in the carrier therefore does not break an ongoing reception. Because the flag is active low, it can also serve directly as a wake request for the rest of a receiver.

Both intervals are counted in sample ticks. The defaults assume a 9600 Hz strobe: 135 ticks (about 14 ms) to acquire and 77 ticks (about 8 ms) to release. The two thresholds are plain inputs, so software or a calibration stage can program them. A power-up enable holds the block idle. An optional register stage on the energy comparison can be selected by parameter.

Top module: `carrier_qualifier`

## Requirements
- R1: After reset the flag `carrier_n` is 1 (no carrier) and both interval counts are zero.
- R2: While the flag is 1, each tick with `energy >= thr_hi` advances the acquisition count. The flag goes to 0 on exactly the ACQ_TICKS-th such tick, and not on the one before.
- R3: While the flag is 1, a tick with `energy < thr_lo` restarts the acquisition count from zero.
- R4: A tick with `thr_lo <= energy < thr_hi` neither advances nor restarts either count.
- R5: While the flag is 0, a run of fewer than REL_TICKS low ticks (`energy < thr_lo`) keeps the flag at 0. A tick with `energy >= thr_hi` restarts the release count.
- R6: While the flag is 0, the flag returns to 1 on exactly the REL_TICKS-th counted low tick.
- R7: While `pwr_en` is 0, the flag is 1 from the next clock on, both counts stay zero and ticks are ignored. After `pwr_en` returns to 1, a full acquisition interval is needed again.
- R8: The flag changes only on the clock that follows the handling of a tick, or because `pwr_en` is 0.
- R9: Changes of `energy` without a tick have no effect on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock sample strobe |
| energy | input | EW | In-band energy estimate, unsigned |
| thr_hi | input | EW | Upper threshold, which counts toward acquisition |
| thr_lo | input | EW | Lower threshold, which counts toward release |
| pwr_en | input | 1 | Power-up enable; 0 holds the block idle |
| carrier_n | output | 1 | Carrier present flag, 0 = present |

## Verification
The bench builds the block with the full 135/77 tick intervals, a 10-bit energy width and the registered comparison variant. This makes the exact acquisition and release boundaries, and the extra stage of latency, observable at the ports. Ticks are spaced four clocks apart, so each tick settles before the flag is sampled. Runs of random length, drawn from the three energy bands, reach mid-band holds, restarted timers and power drops at many count values.

// File: rtl/cq_pkg.sv
`timescale 1ns/1ps
package cq_pkg;
   typedef enum logic [1:0] {
      LVL_LOW  = 2'd0,
      LVL_MID  = 2'd1,
      LVL_HIGH = 2'd2
   } lvl_e;

   typedef enum logic {
      ST_HUNT = 1'b0,
      ST_HOLD = 1'b1
   } st_e;
endpackage

// File: rtl/cq_level_cmp.sv
`timescale 1ns/1ps
module cq_level_cmp
   import cq_pkg::*;
#(
   parameter int EW       = 12,
   parameter bit PIPE_CMP = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pwr_en,
   input  logic          tick,
   input  logic [EW-1:0] energy,
   input  logic [EW-1:0] thr_hi,
   input  logic [EW-1:0] thr_lo,
   output logic          tick_o,
   output lvl_e          lvl_o
);
   lvl_e lvl_c;

   always_comb begin
      if (energy >= thr_hi)     lvl_c = LVL_HIGH;
      else if (energy < thr_lo) lvl_c = LVL_LOW;
      else                      lvl_c = LVL_MID;
   end

   generate
      if (PIPE_CMP) begin : g_pipe
         logic tick_q;
         lvl_e lvl_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tick_q <= 1'b0;
               lvl_q  <= LVL_MID;
            end else begin
               tick_q <= tick & pwr_en;
               lvl_q  <= lvl_c;
            end
         end
         assign tick_o = tick_q;
         assign lvl_o  = lvl_q;
      end else begin : g_comb
         assign tick_o = tick & pwr_en;
         assign lvl_o  = lvl_c;
      end
   endgenerate
endmodule

// File: rtl/cq_run_timer.sv
`timescale 1ns/1ps
module cq_run_timer #(
   parameter int LIMIT = 135,
   localparam int CW   = $clog2(LIMIT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          inc,
   output logic [CW-1:0] cnt,
   output logic          done
);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   assign done = inc && !clr && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (clr)      cnt <= '0;
      else if (done)     cnt <= '0;
      else if (inc)      cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/cq_ctrl.sv
`timescale 1ns/1ps
module cq_ctrl
   import cq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_en,
   input  logic tick,
   input  lvl_e lvl,
   input  logic acq_done,
   input  logic rel_done,
   output logic acq_inc,
   output logic acq_clr,
   output logic rel_inc,
   output logic rel_clr,
   output logic carrier_n
);
   st_e st, st_nx;

   always_comb begin
      acq_inc = pwr_en && (st == ST_HUNT) && tick && (lvl == LVL_HIGH);
      acq_clr = !pwr_en || (st != ST_HUNT) || (tick && (lvl == LVL_LOW));
      rel_inc = pwr_en && (st == ST_HOLD) && tick && (lvl == LVL_LOW);
      rel_clr = !pwr_en || (st != ST_HOLD) || (tick && (lvl == LVL_HIGH));
   end

   always_comb begin
      st_nx = st;
      if (!pwr_en)                          st_nx = ST_HUNT;
      else if (st == ST_HUNT && acq_done)   st_nx = ST_HOLD;
      else if (st == ST_HOLD && rel_done)   st_nx = ST_HUNT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_HUNT;
      else        st <= st_nx;
   end

   assign carrier_n = (st == ST_HUNT);
endmodule

// File: rtl/carrier_qualifier.sv
`timescale 1ns/1ps
module carrier_qualifier
   import cq_pkg::*;
#(
   parameter int EW        = 12,
   parameter int ACQ_TICKS = 135,
   parameter int REL_TICKS = 77,
   parameter bit PIPE_CMP  = 1'b0,
   localparam int AW       = $clog2(ACQ_TICKS),
   localparam int RW       = $clog2(REL_TICKS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic [EW-1:0] energy,
   input  logic [EW-1:0] thr_hi,
   input  logic [EW-1:0] thr_lo,
   input  logic          pwr_en,
   output logic          carrier_n
);
   generate
      if (EW < 2)        begin : g_bad_ew  $error("EW must be at least 2");        end
      if (ACQ_TICKS < 2) begin : g_bad_acq $error("ACQ_TICKS must be at least 2"); end
      if (REL_TICKS < 2) begin : g_bad_rel $error("REL_TICKS must be at least 2"); end
   endgenerate

   logic          tick_q;
   lvl_e          lvl_q;
   logic          acq_inc, acq_clr, acq_done;
   logic          rel_inc, rel_clr, rel_done;
   logic [AW-1:0] acq_cnt;
   logic [RW-1:0] rel_cnt;

   cq_level_cmp #(.EW(EW), .PIPE_CMP(PIPE_CMP)) u_cmp (
      .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .tick(tick),
      .energy(energy), .thr_hi(thr_hi), .thr_lo(thr_lo),
      .tick_o(tick_q), .lvl_o(lvl_q)
   );

   cq_run_timer #(.LIMIT(ACQ_TICKS)) u_acq (
      .clk(clk), .rst_n(rst_n), .clr(acq_clr), .inc(acq_inc),
      .cnt(acq_cnt), .done(acq_done)
   );

   cq_run_timer #(.LIMIT(REL_TICKS)) u_rel (
      .clk(clk), .rst_n(rst_n), .clr(rel_clr), .inc(rel_inc),
      .cnt(rel_cnt), .done(rel_done)
   );

   cq_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .tick(tick_q), .lvl(lvl_q),
      .acq_done(acq_done), .rel_done(rel_done),
      .acq_inc(acq_inc), .acq_clr(acq_clr),
      .rel_inc(rel_inc), .rel_clr(rel_clr),
      .carrier_n(carrier_n)
   );
endmodule

// File: rtl/cq_checker.sv
`timescale 1ns/1ps
module cq_checker #(
   parameter int ACQ_TICKS = 135,
   parameter int REL_TICKS = 77,
   localparam int AW       = $clog2(ACQ_TICKS),
   localparam int RW       = $clog2(REL_TICKS)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          pwr_en,
   input logic          tick_q,
   input logic          carrier_n,
   input logic [AW-1:0] acq_cnt,
   input logic [RW-1:0] rel_cnt
);
   // R1
   reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (carrier_n && acq_cnt == '0 && rel_cnt == '0));

   // R2
   acq_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(carrier_n) |-> (int'($past(acq_cnt)) == ACQ_TICKS - 1));

   // R2
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(acq_cnt) < ACQ_TICKS) && (int'(rel_cnt) < REL_TICKS));

   // R5
   hold_no_acq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !carrier_n |-> (acq_cnt == '0));

   // R6
   rel_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(carrier_n) && $past(pwr_en)) |-> (int'($past(rel_cnt)) == REL_TICKS - 1));

   // R7
   pwr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_en |=> (carrier_n && acq_cnt == '0 && rel_cnt == '0));

   // R8
   quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_q && pwr_en) |=> $stable(carrier_n));
endmodule

bind carrier_qualifier cq_checker #(.ACQ_TICKS(ACQ_TICKS), .REL_TICKS(REL_TICKS)) u_chk (
   .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .tick_q(tick_q),
   .carrier_n(carrier_n), .acq_cnt(acq_cnt), .rel_cnt(rel_cnt)
);

// File: tb/sim_carrier_qualifier.sv
`timescale 1ns/1ps
module sim_carrier_qualifier;
   localparam int EW  = 10;
   localparam int ACQ = 135;
   localparam int REL = 77;
   localparam logic [EW-1:0] HI = 10'd300;
   localparam logic [EW-1:0] LO = 10'd200;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic [EW-1:0] energy = '0;
   logic [EW-1:0] thr_hi = HI;
   logic [EW-1:0] thr_lo = LO;
   logic          pwr_en = 1'b1;
   logic          carrier_n;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   // bench reference state
   bit m_hold = 1'b0;
   int m_acq  = 0;
   int m_rel  = 0;

   always #2 clk = ~clk;

   carrier_qualifier #(.EW(EW), .ACQ_TICKS(ACQ), .REL_TICKS(REL), .PIPE_CMP(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .energy(energy),
      .thr_hi(thr_hi), .thr_lo(thr_lo), .pwr_en(pwr_en), .carrier_n(carrier_n)
   );

   function automatic logic exp_flag();
      return !m_hold;
   endfunction

   function automatic void model_tick(input logic [EW-1:0] e);
      if (!pwr_en) begin
         m_hold = 1'b0; m_acq = 0; m_rel = 0;
      end else if (!m_hold) begin
         if (e >= HI) begin
            m_acq++;
            if (m_acq == ACQ) begin m_hold = 1'b1; m_acq = 0; end
         end else if (e < LO) m_acq = 0;
      end else begin
         if (e < LO) begin
            m_rel++;
            if (m_rel == REL) begin m_hold = 1'b0; m_rel = 0; end
         end else if (e >= HI) m_rel = 0;
      end
   endfunction

   task automatic chk(input logic exp, input string tag);
      checks++;
      if (carrier_n !== exp) begin
         fails++;
         $display("FAIL %s carrier_n=%0b expected=%0b", tag, carrier_n, exp);
      end
   endtask

   task automatic do_tick(input logic [EW-1:0] e, input string tag);
      @(negedge clk); energy = e; tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      model_tick(e);
      @(negedge clk); @(negedge clk);
      chk(exp_flag(), tag);
   endtask

   task automatic run(input int n, input logic [EW-1:0] e, input string tag);
      for (int i = 0; i < n; i++) do_tick(e, tag);
   endtask

   task automatic set_pwr(input logic v);
      @(negedge clk); pwr_en = v;
      if (!v) begin m_hold = 1'b0; m_acq = 0; m_rel = 0; end
      @(negedge clk);
   endtask

   function automatic logic [EW-1:0] rand_in(input int band);
      case (band)
         0:       return EW'($urandom_range(199, 0));
         1:       return EW'($urandom_range(299, 200));
         default: return EW'($urandom_range(1023, 300));
      endcase
   endfunction

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(1'b1, "R1 reset state");

      // R2: exact acquisition boundary
      run(ACQ - 1, 10'd500, "R2 acquiring");
      chk(1'b1, "R2 one tick short");
      do_tick(10'd500, "R2 acquire tick");
      chk(1'b0, "R2 asserted at count");

      // R5: dropout shorter than release, restart by high
      run(REL - 1, 10'd50, "R5 dropout");
      chk(1'b0, "R5 survives short dropout");
      do_tick(10'd400, "R5 restart release");
      run(REL - 1, 10'd50, "R5 second dropout");
      chk(1'b0, "R5 restart honoured");
      // R6: sustained loss
      do_tick(10'd50, "R6 release tick");
      chk(1'b1, "R6 deasserted at count");

      // R3: low sample restarts acquisition
      run(100, 10'd600, "R3 partial");
      do_tick(10'd10, "R3 low restart");
      run(ACQ - 1, 10'd600, "R3 recount");
      chk(1'b1, "R3 restarted count");
      do_tick(10'd600, "R3 final tick");
      chk(1'b0, "R3 asserted after full recount");

      // R4: mid band holds both counts
      run(200, 10'd250, "R4 mid while held");
      chk(1'b0, "R4 mid keeps flag");
      run(REL - 1, 10'd100, "R4 partial release");
      run(50, 10'd299, "R4 mid pause");
      do_tick(10'd199, "R4 release completes");
      chk(1'b1, "R4 release count held across mid");
      run(100, 10'd300, "R4 partial acq");
      run(50, 10'd200, "R4 mid pause acq");
      run(ACQ - 101, 10'd300, "R4 finish acq");
      chk(1'b1, "R4 one short after mid");
      do_tick(10'd300, "R4 acq completes");
      chk(1'b0, "R4 acq count held across mid");

      // R7: power-up enable forces idle
      set_pwr(1'b0);
      chk(1'b1, "R7 forced high");
      run(ACQ + 10, 10'd700, "R7 ticks ignored");
      set_pwr(1'b1);
      run(ACQ - 1, 10'd700, "R7 fresh acquisition");
      chk(1'b1, "R7 timers were cleared");
      do_tick(10'd700, "R7 reacquire");

      // R9: energy without tick
      run(REL, 10'd20, "R9 drop to idle");
      @(negedge clk); energy = 10'd900;
      repeat (ACQ * 3) @(negedge clk);
      chk(1'b1, "R9 no tick no change");

      // R8: random runs against the bench model
      for (int r = 0; r < 120; r++) begin
         int band = int'($urandom_range(2, 0));
         int len  = int'($urandom_range(160, 1));
         if ($urandom_range(15, 0) == 0) set_pwr(1'b0);
         else if (!pwr_en) set_pwr(1'b1);
         for (int k = 0; k < len; k++) begin
            int b = ($urandom_range(7, 0) == 0) ? int'($urandom_range(2, 0)) : band;
            do_tick(rand_in(b), "R8 random");
         end
      end

      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog run did not complete actual=hung expected=done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule